// File: doc/BRIEF.md
# Quadrature Encoder Count-Pulse Converter

This block takes the two phase signals of an incremental encoder and turns them into count strobes for an ordinary up/down counter. Each phase is brought into the clock domain by a short synchroniser chain. It then passes through a validation filter, which accepts a new level only after that level has held for a fixed number of cycles. This removes contact bounce and dither at a standstill.

The filtered pair is decoded as a Gray-code sequence. A resolution select picks which edges count: one, two or four per quadrature cycle. A small state machine turns each count event into an active-low strobe whose length is set at run time. There are two output styles, chosen by a format select. The split style gives separate up and down strobes. The combined style gives a single strobe plus a direction level, which is set before the strobe falls.

Events that arrive while a strobe is in progress are held in a one-deep queue. If a further event arrives while the queue is full, a sticky overrun flag is set. If both phases change in the same sample, no strobe is produced and a sticky error flag is set. Both flags are cleared by a clear input.

The pulse state machine has four states:
- IDLE: no strobe is pending.
- ARM: a high cycle in which the direction level is loaded.
- PULSE: the strobe is low for the programmed number of cycles.
- GAP: a high cycle after each strobe.

Its transitions are:
- IDLE→ARM on an event.
- ARM→PULSE always.
- PULSE→PULSE while the remaining count is above one.
- PULSE→GAP when the count reaches one.
- GAP→ARM when an event is queued or arriving.
- GAP→IDLE otherwise.

Top module: `qenc_converter`

## Requirements
- R1: While reset is held and after it is released with still inputs, up_n, dn_n and cnt_n are high, dir is high, and both error flags are low.
- R2: A change on either encoder input that lasts fewer than VALID_CYCLES clock cycles (default 4) produces no strobe. A change that lasts VALID_CYCLES cycles is accepted.
- R3: res_sel picks the counting edges. 2'b00 counts only the rising edge of filtered A. 2'b01 counts both edges of A. 2'b10 and 2'b11 count every edge of A or B.
- R4: With fmt_combined = 0, forward motion (A leads B, phase order AB = 00, 10, 11, 01) gives low strobes on up_n only. Reverse motion gives low strobes on dn_n only. cnt_n stays high. up_n and dn_n are never low together.
- R5: With fmt_combined = 1, every count strobe appears on cnt_n, and up_n and dn_n stay high. During a strobe, dir is 1 for forward motion and 0 for reverse motion.
- R6: dir changes only while cnt_n is high. It has its new value at least one cycle before cnt_n falls, and it keeps that value through the cycle in which cnt_n rises.
- R7: Each strobe is low for exactly pulse_width cycles. A pulse_width of 0 gives a one-cycle strobe.
- R8: When both filtered inputs change in the same cycle, no strobe is produced and illegal_err goes high. illegal_err stays high until err_clear is asserted.
- R9: An event that arrives during a strobe is queued and issued afterwards. Successive strobes are separated by at least two high cycles.
- R10: An event that arrives while one is already queued is dropped and sets overrun_err. overrun_err stays high until err_clear is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| res_sel | input | 2 | Resolution select (00 x1, 01 x2, 10/11 x4) |
| fmt_combined | input | 1 | 0 split up/down strobes, 1 single strobe plus direction |
| pulse_width | input | PW_BITS | Strobe low time in cycles (0 acts as 1) |
| err_clear | input | 1 | Clears both sticky flags |
| up_n | output | 1 | Active-low up strobe (split format) |
| dn_n | output | 1 | Active-low down strobe (split format) |
| cnt_n | output | 1 | Active-low count strobe (combined format) |
| dir | output | 1 | Direction level, 1 forward |
| illegal_err | output | 1 | Sticky flag: both phases changed together |
| overrun_err | output | 1 | Sticky flag: a queued event was lost |

## Verification
The hardest conditions to reach from the ports are the full queue and the simultaneous phase change. Filtering and synchronisation normally space events well apart. To fill the queue, the bench programs a strobe far longer than the step spacing and sends three quick steps, so that the third step lands while the first strobe is still low and the second step is queued. For the simultaneous change, both inputs are driven on the same clock sample, so the two filters accept the new levels in the same cycle. The bench also sends glitches one cycle shorter than the validation time and glitches exactly as long as it, to test the filter boundary.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam logic [1:0] RES_X1 = 2'b00;
    localparam logic [1:0] RES_X2 = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_PULSE = 2'd2,
        ST_GAP   = 2'd3
    } pulse_state_e;

    typedef struct packed {
        logic valid;
        logic up;
    } cnt_evt_t;

endpackage

// File: rtl/qenc_filter.sv
module qenc_filter #(
    parameter int SYNC_STAGES  = 2,
    parameter int VALID_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(VALID_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          stable_cnt;
    logic                   synced;

    // the chain samples continuously so reset can load the live level
    always_ff @(posedge clk) begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            level      <= synced;
            stable_cnt <= '0;
        end else if (synced != level) begin
            if (stable_cnt == CW'(VALID_CYCLES - 1)) begin
                level      <= synced;
                stable_cnt <= '0;
            end else begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end else begin
            stable_cnt <= '0;
        end
    end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       filt_a,
    input  logic       filt_b,
    input  logic [1:0] res_sel,
    output cnt_evt_t   evt,
    output logic       illegal
);
    logic prev_a, prev_b;
    logic chg_a, chg_b, single, fwd;

    always_ff @(posedge clk) begin
        prev_a <= filt_a;
        prev_b <= filt_b;
        if (rst) begin
            prev_a <= filt_a;
            prev_b <= filt_b;
        end
    end

    always_comb begin
        chg_a   = filt_a ^ prev_a;
        chg_b   = filt_b ^ prev_b;
        single  = chg_a ^ chg_b;
        illegal = chg_a & chg_b;
        // Gray order 00,10,11,01 is forward
        fwd     = chg_a ? (filt_a != filt_b) : (filt_a == filt_b);
        evt.up  = fwd;
        unique case (res_sel)
            RES_X1:  evt.valid = chg_a & ~chg_b & filt_a;
            RES_X2:  evt.valid = chg_a & ~chg_b;
            default: evt.valid = single;
        endcase
    end

endmodule

// File: rtl/qenc_pulser.sv
module qenc_pulser
    import qenc_pkg::*;
#(
    parameter int PW_BITS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  cnt_evt_t           evt,
    input  logic [PW_BITS-1:0] pulse_width,
    input  logic               fmt_combined,
    output logic               up_n,
    output logic               dn_n,
    output logic               cnt_n,
    output logic               dir,
    output logic               overrun_set
);
    pulse_state_e       state, state_nx;
    logic [PW_BITS-1:0] remain;
    logic [PW_BITS-1:0] width_eff;
    logic               cur_up;
    logic               pend_v, pend_up;
    logic               take_pend, take_direct, store_evt;

    assign width_eff = (pulse_width == '0) ? PW_BITS'(1) : pulse_width;

    always_comb begin
        take_pend   = (state == ST_GAP) && pend_v;
        take_direct = evt.valid && ((state == ST_IDLE) || ((state == ST_GAP) && !pend_v));
        store_evt   = evt.valid && !take_direct;
        overrun_set = store_evt && pend_v && !take_pend;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = take_direct ? ST_ARM : ST_IDLE;
            ST_ARM:   state_nx = ST_PULSE;
            ST_PULSE: state_nx = (remain == PW_BITS'(1)) ? ST_GAP : ST_PULSE;
            ST_GAP:   state_nx = (take_pend || take_direct) ? ST_ARM : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // datapath: direction, width counter, one-deep queue
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_up  <= 1'b1;
            remain  <= PW_BITS'(1);
            pend_v  <= 1'b0;
            pend_up <= 1'b1;
        end else begin
            if (state_nx == ST_ARM)
                cur_up <= take_pend ? pend_up : evt.up;
            if (state == ST_ARM)
                remain <= width_eff;
            else if (state == ST_PULSE)
                remain <= remain - 1'b1;
            if (store_evt && (!pend_v || take_pend)) begin
                pend_v  <= 1'b1;
                pend_up <= evt.up;
            end else if (take_pend) begin
                pend_v  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        up_n  = ~((state == ST_PULSE) && !fmt_combined && cur_up);
        dn_n  = ~((state == ST_PULSE) && !fmt_combined && !cur_up);
        cnt_n = ~((state == ST_PULSE) && fmt_combined);
        dir   = cur_up;
    end

endmodule

// File: rtl/qenc_converter.sv
module qenc_converter
    import qenc_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int VALID_CYCLES = 4,
    parameter int PW_BITS      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enc_a,
    input  logic               enc_b,
    input  logic [1:0]         res_sel,
    input  logic               fmt_combined,
    input  logic [PW_BITS-1:0] pulse_width,
    input  logic               err_clear,
    output logic               up_n,
    output logic               dn_n,
    output logic               cnt_n,
    output logic               dir,
    output logic               illegal_err,
    output logic               overrun_err
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in, filt;
    cnt_evt_t       evt;
    logic           illegal, overrun_set;

    assign raw_in = {enc_b, enc_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_filt
        qenc_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .VALID_CYCLES(VALID_CYCLES)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_in[ch]),
            .level(filt[ch])
        );
    end

    qenc_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .filt_a (filt[0]),
        .filt_b (filt[1]),
        .res_sel(res_sel),
        .evt    (evt),
        .illegal(illegal)
    );

    qenc_pulser #(.PW_BITS(PW_BITS)) u_pls (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .pulse_width (pulse_width),
        .fmt_combined(fmt_combined),
        .up_n        (up_n),
        .dn_n        (dn_n),
        .cnt_n       (cnt_n),
        .dir         (dir),
        .overrun_set (overrun_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            illegal_err <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            if (illegal)        illegal_err <= 1'b1;
            else if (err_clear) illegal_err <= 1'b0;
            if (overrun_set)    overrun_err <= 1'b1;
            else if (err_clear) overrun_err <= 1'b0;
        end
    end

endmodule

// File: rtl/qenc_checker.sv
module qenc_checker (
    input logic clk,
    input logic rst,
    input logic err_clear,
    input logic fmt_combined,
    input logic up_n,
    input logic dn_n,
    input logic cnt_n,
    input logic dir,
    input logic illegal_err,
    input logic overrun_err
);

    assert_split_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(!up_n && !dn_n));

    assert_combined_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        fmt_combined |-> (up_n && dn_n));

    assert_split_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !fmt_combined |-> cnt_n);

    assert_dir_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!cnt_n || !$past(cnt_n)) |-> $stable(dir));

    assert_cnt_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cnt_n) |=> cnt_n);

    assert_up_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(up_n) |=> (up_n && dn_n));

    assert_illegal_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (illegal_err && !err_clear) |=> illegal_err);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (overrun_err && !err_clear) |=> overrun_err);

endmodule

bind qenc_converter qenc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .err_clear   (err_clear),
    .fmt_combined(fmt_combined),
    .up_n        (up_n),
    .dn_n        (dn_n),
    .cnt_n       (cnt_n),
    .dir         (dir),
    .illegal_err (illegal_err),
    .overrun_err (overrun_err)
);

// File: tb/qenc_converter_bench.sv
module qenc_converter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VALID      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_a = 1'b0, enc_b = 1'b0;
    logic [1:0] res_sel = 2'b10;
    logic       fmt_combined = 1'b0;
    logic [7:0] pulse_width = 8'd1;
    logic       err_clear = 1'b0;
    logic       up_n, dn_n, cnt_n, dir, illegal_err, overrun_err;

    int tests = 0, fails = 0;
    int n_up = 0, n_dn = 0, n_cu = 0, n_cd = 0;
    int exp_w = 1;
    int p = 0;
    int exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qenc_converter #(.VALID_CYCLES(VALID)) u_qenc_converter (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .res_sel(res_sel), .fmt_combined(fmt_combined),
        .pulse_width(pulse_width), .err_clear(err_clear),
        .up_n(up_n), .dn_n(dn_n), .cnt_n(cnt_n), .dir(dir),
        .illegal_err(illegal_err), .overrun_err(overrun_err)
    );

    function automatic void chk(bit ok, string req, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endfunction

    // monitor on the falling edge, away from the active edge
    logic pu = 1, pd = 1, pc = 1, pdir = 1, plow = 0;
    int   lowlen = 0, highlen = 100;
    always @(negedge clk) begin
        if (rst) begin
            pu = 1; pd = 1; pc = 1; pdir = 1; plow = 0;
            lowlen = 0; highlen = 100;
        end else begin
            logic low;
            low = !(up_n && dn_n && cnt_n);
            if (pu && !up_n) n_up++;
            if (pd && !dn_n) n_dn++;
            if (pc && !cnt_n) begin
                if (dir) n_cu++; else n_cd++;
                chk(dir == pdir, "R6 dir settled before fall", dir, pdir);
            end
            if (!pc && cnt_n)
                chk(dir == pdir, "R6 dir held through rise", dir, pdir);
            if (low) begin
                if (!plow) begin
                    chk(highlen >= 2, "R9 high gap between strobes", highlen, 2);
                    highlen = 0;
                end
                lowlen++;
            end else begin
                if (plow) begin
                    chk(lowlen == exp_w, "R7 strobe width", lowlen, exp_w);
                    lowlen = 0;
                end
                highlen++;
            end
            pu = up_n; pd = dn_n; pc = cnt_n; pdir = dir; plow = low;
        end
    end

    function automatic bit ph_a(int q); return (q == 1) || (q == 2); endfunction
    function automatic bit ph_b(int q); return (q == 2) || (q == 3); endfunction

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_up = 0; n_dn = 0; n_cu = 0; n_cd = 0; exp_n = 0;
    endtask

    task automatic set_pw(int w);
        pulse_width = 8'(w);
        exp_w = (w == 0) ? 1 : w;
    endtask

    task automatic step(bit fwd, int spacing);
        int  np;
        bit  ao, an;
        np = fwd ? (p + 1) % 4 : (p + 3) % 4;
        ao = ph_a(p);
        an = ph_a(np);
        if (res_sel == 2'b00)      exp_n += (!ao && an) ? 1 : 0;
        else if (res_sel == 2'b01) exp_n += (ao != an) ? 1 : 0;
        else                       exp_n += 1;
        p = np;
        @(negedge clk);
        enc_a = ph_a(p);
        enc_b = ph_b(p);
        wait_cyc(spacing);
    endtask

    task automatic pulse_clear();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
        wait_cyc(1);
    endtask

    initial begin : main
        // R1 reset state
        wait_cyc(6);
        chk(up_n && dn_n && cnt_n, "R1 strobes high in reset", {up_n, dn_n, cnt_n}, 7);
        chk(dir == 1'b1, "R1 dir high in reset", dir, 1);
        @(negedge clk); rst = 1'b0;
        wait_cyc(10);
        chk(up_n && dn_n && cnt_n, "R1 strobes high after reset", {up_n, dn_n, cnt_n}, 7);
        chk(!illegal_err && !overrun_err, "R1 flags low", {illegal_err, overrun_err}, 0);

        // R3 R4 R5 R7 sweep over format, resolution, direction
        for (int f = 0; f < 2; f++) begin
            for (int r = 0; r < 4; r++) begin
                for (int d = 0; d < 2; d++) begin
                    int wsel;
                    fmt_combined = f[0];
                    res_sel = 2'(r);
                    wsel = (r + f + d) % 4;
                    set_pw(wsel == 0 ? 0 : (wsel == 1 ? 1 : (wsel == 2 ? 3 : 7)));
                    wait_cyc(4);
                    clear_counts();
                    for (int s = 0; s < 8; s++) step(d == 0, 24);
                    if (f == 0) begin
                        chk(n_up == (d == 0 ? exp_n : 0), "R3 R4 up strobes", n_up, d == 0 ? exp_n : 0);
                        chk(n_dn == (d == 1 ? exp_n : 0), "R3 R4 down strobes", n_dn, d == 1 ? exp_n : 0);
                        chk(n_cu + n_cd == 0, "R4 cnt_n quiet", n_cu + n_cd, 0);
                    end else begin
                        chk(n_cu == (d == 0 ? exp_n : 0), "R3 R5 forward strobes", n_cu, d == 0 ? exp_n : 0);
                        chk(n_cd == (d == 1 ? exp_n : 0), "R3 R5 reverse strobes", n_cd, d == 1 ? exp_n : 0);
                        chk(n_up + n_dn == 0, "R5 split outputs quiet", n_up + n_dn, 0);
                    end
                end
            end
        end

        // R2 filter boundary
        fmt_combined = 1'b0; res_sel = 2'b10; set_pw(1);
        wait_cyc(4); clear_counts();
        enc_a = ~enc_a; wait_cyc(VALID - 1); enc_a = ~enc_a; wait_cyc(30);
        chk(n_up + n_dn == 0, "R2 short glitch ignored", n_up + n_dn, 0);
        clear_counts();
        enc_a = ~enc_a; wait_cyc(VALID); enc_a = ~enc_a; wait_cyc(30);
        chk(n_up + n_dn == 2, "R2 glitch of validation length accepted", n_up + n_dn, 2);

        // R8 simultaneous change
        set_pw(2); clear_counts();
        p = (p + 2) % 4;
        enc_a = ph_a(p); enc_b = ph_b(p);
        wait_cyc(30);
        chk(n_up + n_dn == 0, "R8 no strobe on illegal change", n_up + n_dn, 0);
        chk(illegal_err == 1'b1, "R8 illegal flag set", illegal_err, 1);
        step(1'b1, 30);
        chk(illegal_err == 1'b1, "R8 illegal flag sticky", illegal_err, 1);
        chk(n_up == 1, "R8 legal step after illegal", n_up, 1);
        pulse_clear();
        chk(illegal_err == 1'b0, "R8 illegal flag cleared", illegal_err, 0);

        // R9 queued event
        set_pw(12); clear_counts();
        step(1'b1, 8); step(1'b1, 60);
        chk(n_up == 2, "R9 queued event issued", n_up, 2);
        chk(overrun_err == 1'b0, "R9 no overrun with one queued", overrun_err, 0);

        // R10 overrun
        set_pw(40); clear_counts();
        step(1'b1, 8); step(1'b1, 8); step(1'b1, 150);
        chk(n_up == 2, "R10 third event dropped", n_up, 2);
        chk(overrun_err == 1'b1, "R10 overrun flag set", overrun_err, 1);
        pulse_clear();
        chk(overrun_err == 1'b0, "R10 overrun flag cleared", overrun_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule